// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial characters as the clock master of a two-wire synchronous link. It drives a clock it generates itself onto a clock pin and reads bits from a separate data pin. The peer device changes its data on the rising edge of that clock. The receiver samples the data pin on the falling edge, least significant bit first, and assembles a character of 8 or 9 bits.

Two controls start reception. A one-shot request (`single_set`) arms a flag that produces exactly one character's worth of clock pulses and then clears itself. A level enable (`cont_en`) keeps characters coming back to back for as long as it is held. Dropping `cont_en` while the one-shot flag is clear stops the clock at once and throws away the bits gathered so far.

The clock half-period comes from a programmable divider. Each finished character goes out as a one-cycle push to a downstream buffer. The buffer's `stall` input holds off the next character while that buffer has an overrun pending.

Top module: `sync_rx_master`

## Requirements
- R1: After a `single_set` pulse with `cont_en` low, the block produces exactly as many rising edges on `ser_clk` as the character has bits, then stops. `single_busy` falls in the same cycle as the push.
- R2: While `cont_en` is high, characters follow one another with no idle gap: the low time between the last pulse of one character and the first pulse of the next equals one normal half-period.
- R3: When both `cont_en` and `single_busy` are low partway through a character, `ser_clk` is low after the next clock edge, no push occurs, and the partial bits do not appear in any later character.
- R4: When `single_set` and `cont_en` are both active, `single_busy` clears at the first push and reception continues under `cont_en`.
- R5: `ser_din` is sampled at the clock edge on which `ser_clk` falls. The first bit sampled goes to `push_data[0]` and the bits that follow go to higher positions.
- R6: With `nine_bit` high a character has 9 bits. With it low a character has 8 bits and `push_data[8]` is 0.
- R7: Each high phase and each low phase of `ser_clk` during reception lasts `div_val`+1 system clock cycles. `ser_clk` is low whenever reception is idle.
- R8: While `stall` is high, no new character starts (no rising edge on `ser_clk` from idle). A character already in progress completes and is pushed.
- R9: `ser_dout_en` is 0 at all times, so the data pin driver stays off.
- R10: `push` is a single-cycle strobe. It is high in the cycle after the edge on which the last bit was sampled, with the completed character on `push_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_set | input | 1 | Pulse that arms one-character reception |
| cont_en | input | 1 | Level enable for continuous reception |
| nine_bit | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit characters |
| stall | input | 1 | Buffer overrun pending; blocks the start of new characters |
| div_val | input | DIV_W | Half-period of `ser_clk` minus one, in system cycles |
| ser_din | input | 1 | Serial data pin |
| ser_clk | output | 1 | Generated serial clock, idles low |
| ser_dout_en | output | 1 | Output enable for the data pin driver, always 0 |
| single_busy | output | 1 | One-shot request flag; clears itself |
| push | output | 1 | One-cycle strobe for a completed character |
| push_data | output | 9 | Completed character |

## Verification
The divider starts counting in the first cycle in which reception is enabled. `ser_clk` therefore rises after `div_val`+1 edges and falls after another `div_val`+1 edges. The sample and the push register on the final falling edge, so `push` and the cleared `single_busy` are both visible at the negedge straight after that edge. An abort shows as a low `ser_clk` one edge after the enables drop. The bench samples every output at the falling edge of `clk`. It drives data bits only at the negedge following a rising `ser_clk`, so each bit is stable across the sampling edge. Pulse widths are measured continuously by a monitor and compared against `div_val`+1 rather than at fixed times.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_set,
  input  logic             cont_en,
  input  logic             nine_bit,
  input  logic             stall,
  input  logic [DIV_W-1:0] div_val,
  input  logic             ser_din,
  output logic             ser_clk,
  output logic             ser_dout_en,
  output logic             single_busy,
  output logic             push,
  output logic [8:0]       push_data
);
  logic [DIV_W-1:0] divcnt;
  logic [3:0]       bitcnt;
  logic [8:0]       shreg, captured;
  logic             sgl, sclk;

  wire enabled = sgl | cont_en;
  wire mid     = sclk | (bitcnt != 4'd0);
  wire go      = enabled & (mid | ~stall);
  wire tick    = go & (divcnt == div_val);
  wire trail   = tick & sclk;
  wire [3:0] last_idx = nine_bit ? 4'd8 : 4'd7;
  wire last    = trail & (bitcnt == last_idx);

  always_comb begin
    captured = shreg;
    captured[bitcnt] = ser_din;
    if (!nine_bit) captured[8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divcnt    <= '0;
      bitcnt    <= '0;
      shreg     <= '0;
      sclk      <= 1'b0;
      sgl       <= 1'b0;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push <= last;
      if (last) push_data <= captured;
      if (single_set) sgl <= 1'b1;
      else if (last)  sgl <= 1'b0;
      if (!go) begin
        divcnt <= '0;
        sclk   <= 1'b0;
        bitcnt <= '0;
      end else if (tick) begin
        divcnt <= '0;
        sclk   <= ~sclk;
        if (sclk) begin
          shreg  <= captured;
          bitcnt <= last ? 4'd0 : 4'(bitcnt + 4'd1);
        end
      end else begin
        divcnt <= DIV_W'(divcnt + 1'b1);
      end
    end
  end

  assign ser_clk     = sclk;
  assign single_busy = sgl;
  assign ser_dout_en = 1'b0;
endmodule

module sync_rx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cont_en,
  input logic       stall,
  input logic       ser_clk,
  input logic       single_busy,
  input logic       push,
  input logic [3:0] bitcnt
);
  p_push_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(ser_clk) && !ser_clk));
  p_abort_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_busy && !cont_en) |=> !ser_clk);
  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_clk) && $past(bitcnt == 4'd0)) |-> !$past(stall));
  p_single_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_busy) |-> push);
  p_push_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
endmodule

bind sync_rx_master sync_rx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .stall(stall),
  .ser_clk(ser_clk), .single_busy(single_busy), .push(push), .bitcnt(bitcnt)
);

// File: tb/sim_sync_rx_master.sv
`timescale 1ns/1ps
module sim_sync_rx_master;
  logic clk = 0, rst_n = 0, single_set = 0, cont_en = 0, nine_bit = 0, stall = 0, ser_din = 0;
  logic [7:0] div_val = 8'd2;
  logic ser_clk, ser_dout_en, single_busy, push;
  logic [8:0] push_data;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  sync_rx_master #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .single_set(single_set), .cont_en(cont_en),
    .nine_bit(nine_bit), .stall(stall), .div_val(div_val), .ser_din(ser_din),
    .ser_clk(ser_clk), .ser_dout_en(ser_dout_en), .single_busy(single_busy),
    .push(push), .push_data(push_data));

  logic [8:0] words [0:3];
  int widx = 0, bidx = 0, nbits = 8;
  int rises = 0, pushes = 0, hi_len = 0, lo_len = 0, bad_w = 0, dbl_push = 0, oe_bad = 0;
  logic [8:0] pd_log [0:7];
  logic prev_clk = 0, prev_push = 0, seen_pulse = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (ser_dout_en !== 1'b0) oe_bad <= oe_bad + 1;
    if (ser_clk && !prev_clk) begin
      rises <= rises + 1;
      ser_din <= words[widx][bidx];
      if (bidx + 1 == nbits) begin bidx <= 0; widx <= (widx + 1) % 4; end
      else bidx <= bidx + 1;
      if (seen_pulse && lo_len != div_val + 1) bad_w <= bad_w + 1;
      hi_len <= 1;
    end else if (ser_clk) hi_len <= hi_len + 1;
    if (!ser_clk && prev_clk) begin
      if (hi_len != div_val + 1) bad_w <= bad_w + 1;
      seen_pulse <= 1; lo_len <= 1;
    end else if (!ser_clk) lo_len <= lo_len + 1;
    if (!ser_clk && !prev_clk && lo_len > div_val + 1) seen_pulse <= 0;
    if (push) begin
      if (pushes < 8) pd_log[pushes] <= push_data;
      pushes <= pushes + 1;
      if (prev_push) dbl_push <= dbl_push + 1;
    end
    prev_clk <= ser_clk;
    prev_push <= push;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pushes(input int n);
    for (int i = 0; i < 5000 && pushes < n; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(negedge clk);
    rises = 0; pushes = 0; bad_w = 0; dbl_push = 0; widx = 0; bidx = 0; seen_pulse = 0;
  endtask

  task automatic t_reset();
    chk("R7 idle clk", ser_clk, 0);
    chk("R10 idle push", push, 0);
    chk("R1 idle busy", single_busy, 0);
    chk("R9 oe", ser_dout_en, 0);
  endtask

  task automatic t_single8();
    div_val = 2; nine_bit = 0; nbits = 8; words[0] = 9'h1A5;
    clear_mon();
    single_set = 1; @(negedge clk); single_set = 0;
    wait_pushes(1);
    chk("R1 busy cleared with push", single_busy, 0);
    chk("R5 R6 data 8-bit", push_data, 9'h0A5);
    cycles(30);
    chk("R1 pulse count", rises, 8);
    chk("R1 one push", pushes, 1);
    chk("R7 widths", bad_w, 0);
    chk("R10 single strobe", dbl_push, 0);
  endtask

  task automatic t_single9();
    div_val = 0; nine_bit = 1; nbits = 9; words[0] = 9'h1C3;
    clear_mon();
    single_set = 1; @(negedge clk); single_set = 0;
    wait_pushes(1);
    chk("R6 data 9-bit", push_data, 9'h1C3);
    cycles(20);
    chk("R6 pulse count 9", rises, 9);
    chk("R7 widths div0", bad_w, 0);
  endtask

  task automatic t_cont();
    div_val = 1; nine_bit = 0; nbits = 8;
    words[0] = 9'h011; words[1] = 9'h022; words[2] = 9'h0F0; words[3] = 9'h0AA;
    clear_mon();
    cont_en = 1;
    wait_pushes(3);
    cont_en = 0;
    cycles(30);
    chk("R2 char0", pd_log[0], 9'h011);
    chk("R2 char1", pd_log[1], 9'h022);
    chk("R2 char2", pd_log[2], 9'h0F0);
    chk("R2 no gap widths", bad_w, 0);
    chk("R2 stop count", pushes, 3);
    chk("R10 strobes", dbl_push, 0);
  endtask

  task automatic t_abort();
    div_val = 1; nine_bit = 0; nbits = 8; words[0] = 9'h0FF;
    clear_mon();
    cont_en = 1;
    for (int i = 0; i < 500 && rises < 3; i++) @(negedge clk);
    cont_en = 0;
    @(negedge clk);
    chk("R3 clock stops", ser_clk, 0);
    cycles(20);
    chk("R3 no push", pushes, 0);
    words[0] = 9'h03C;
    clear_mon();
    single_set = 1; @(negedge clk); single_set = 0;
    wait_pushes(1);
    chk("R3 partial discarded", push_data, 9'h03C);
  endtask

  task automatic t_both();
    div_val = 0; nine_bit = 0; nbits = 8; words[0] = 9'h055; words[1] = 9'h0C7;
    clear_mon();
    single_set = 1; cont_en = 1; @(negedge clk); single_set = 0;
    wait_pushes(1);
    chk("R4 single cleared", single_busy, 0);
    wait_pushes(2);
    cont_en = 0;
    chk("R4 first", pd_log[0], 9'h055);
    chk("R4 continues", push_data, 9'h0C7);
  endtask

  task automatic t_stall();
    div_val = 1; nine_bit = 0; nbits = 8; words[0] = 9'h081; words[1] = 9'h066;
    clear_mon();
    stall = 1; cont_en = 1;
    cycles(40);
    chk("R8 no start", rises, 0);
    stall = 0;
    for (int i = 0; i < 500 && rises < 3; i++) @(negedge clk);
    stall = 1;
    wait_pushes(1);
    chk("R8 in-progress completes", push_data, 9'h081);
    cycles(40);
    chk("R8 blocked after", rises, 8);
    cont_en = 0; stall = 0;
    cycles(4);
    chk("R9 oe never set", oe_bad, 0);
  endtask

  initial begin
    words[0] = 0; words[1] = 0; words[2] = 0; words[3] = 0;
    cycles(4);
    t_reset();
    rst_n = 1;
    cycles(2);
    t_single8();
    t_single9();
    t_cont();
    t_abort();
    t_both();
    t_stall();
    finish_run();
  end
endmodule